// File: doc/BRIEF.md
# Hardware Cursor Overlay Mixer

This block places a 32 by 32 two-colour cursor over the video pixel stream. Each clock it receives the scan coordinates of the pixel being produced, the active line width and that pixel's colour from upstream. It returns one of three things: the incoming colour unchanged, or one of two overlay colours that the palette supplies on dedicated inputs.

The cursor shape is held in two banks of 32 row words. The transparency bank says whether a pixel is drawn, and the shade bank picks which overlay colour is used. In every row word, bit 31 is the leftmost pixel. The position word and both banks are written through a simple register port. These writes go into a pending copy. The copy used for drawing is refreshed only when a frame-start pulse arrives, so a cursor update never tears partway through a frame.

A miscellaneous word sits on the same port. It reads back with one status bit forced high. Every other offset reads as zero.

Top module: `cursor_ovl_top`

## Requirements
- R1: After reset the cursor X and Y are both 0xF000 and every row word is zero, so pixOut equals pixIn at every scan position, and a misc read returns 0x02000000.
- R2: A write to byte offset 0x8FC loads cursor X from bits 31:16 and cursor Y from bits 15:0.
- R3: A write to offset 0x900 + 4r loads transparency row r, and a write to 0x980 + 4r loads shade row r, for r = 0..31. The row number is (offset - base) >> 2.
- R4: The cursor covers scan lines cursY to cursY+31 and columns cursX to cursX+31. Pixel (x, y) uses bit 31 - (x - cursX) of row y - cursY.
- R5: A clear transparency bit passes pixIn. A set transparency bit with a set shade bit outputs ovlSetColor. A set transparency bit with a clear shade bit outputs ovlClrColor.
- R6: No cursor pixel is drawn at a column at or beyond activeWidth, so the visible run is min(activeWidth - cursX, 32). Nothing is drawn when cursX >= activeWidth.
- R7: A write to offset 0x818 stores the misc word, and the next read of 0x818 returns it with bit 25 forced to 1. The read data appears one cycle after regRdEn.
- R8: A read of any offset other than 0x818 returns zero, including the position and row offsets.
- R9: Position and row writes have no visible effect until frameStart is pulsed. From the cycle after the pulse, drawing uses all values written before it.
- R10: pixOut is registered: it reflects the scan inputs presented one clock earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regAddr | input | 12 | Byte offset of access |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data, one cycle after regRdEn |
| frameStart | input | 1 | Pulse that commits pending cursor state |
| scanX | input | 16 | Current pixel column |
| scanY | input | 16 | Current scan line |
| activeWidth | input | 16 | Active pixels per line |
| pixIn | input | 24 | Incoming pixel colour |
| ovlSetColor | input | 24 | Overlay colour for shade bit 1 |
| ovlClrColor | input | 24 | Overlay colour for shade bit 0 |
| pixOut | output | 24 | Mixed pixel colour |

## Verification
The bench sweeps every scan position over and around the cursor square for several placements, and predicts each output pixel from its own copy of the row words. This exposes bit-order mistakes, which would mirror the cursor horizontally. It also exposes a one-off window edge, which would add or drop a line or column, and swapped overlay colours.

Two placements test right-edge clipping: one straddles activeWidth and one starts exactly at it. A design that skipped the clip would draw past the line end. One that tested only cursX would draw the whole run or none of it.

Sweeps taken before the frame-start pulse catch a design that applies writes immediately. Separate writes to rows 0 and 31 test the offset-to-row mapping. Reads of the misc, position and row offsets catch a missing forced bit or stray readback.

// File: rtl/cursor_ovl_pkg.sv
package cursor_ovl_pkg;
  localparam int DATA_W   = 32;                 // register width == cursor size
  localparam int ADDR_W   = 12;
  localparam int ROW_W    = $clog2(DATA_W);
  localparam int PAGE_LSB = ROW_W + 2;          // rows are word spaced

  localparam logic [ADDR_W-1:0] MISC_OFS = 12'h818;
  localparam logic [ADDR_W-1:0] POS_OFS  = 12'h8FC;
  localparam logic [ADDR_W-1:0] MASK_BASE = 12'h900;
  localparam logic [ADDR_W-1:0] IMG_BASE  = 12'h980;
  localparam logic [ADDR_W-PAGE_LSB-1:0] MASK_PAGE = MASK_BASE[ADDR_W-1:PAGE_LSB];
  localparam logic [ADDR_W-PAGE_LSB-1:0] IMG_PAGE  = IMG_BASE[ADDR_W-1:PAGE_LSB];

  localparam int MISC_FORCE_BIT = 25;
  localparam int RESET_COORD    = 'hF000;

  typedef struct packed {
    logic              load;     // commit pending -> active
    logic              wrPos;
    logic              wrMask;
    logic              wrImg;
    logic              wrMisc;
    logic              rdMisc;
    logic              rdOther;
    logic [ROW_W-1:0]  row;
    logic [DATA_W-1:0] data;
  } cursStrobe_t;
endpackage

// File: rtl/cursor_ovl_ctl.sv
module cursor_ovl_ctl
  import cursor_ovl_pkg::*;
(
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  logic              frameStart,
  output cursStrobe_t       strobe
);
  logic hitMisc, hitPos, hitMask, hitImg;

  always_comb begin
    hitMisc = (regAddr == MISC_OFS);
    hitPos  = (regAddr == POS_OFS);
    hitMask = (regAddr[ADDR_W-1:PAGE_LSB] == MASK_PAGE);
    hitImg  = (regAddr[ADDR_W-1:PAGE_LSB] == IMG_PAGE);

    strobe         = '0;
    strobe.load    = frameStart;
    strobe.wrPos   = regWrEn & hitPos;
    strobe.wrMask  = regWrEn & hitMask;
    strobe.wrImg   = regWrEn & hitImg;
    strobe.wrMisc  = regWrEn & hitMisc;
    strobe.rdMisc  = regRdEn & hitMisc;
    strobe.rdOther = regRdEn & ~hitMisc;
    strobe.row     = regAddr[PAGE_LSB-1:2];
    strobe.data    = regWrData;
  end
endmodule

// File: rtl/cursor_ovl_dp.sv
module cursor_ovl_dp
  import cursor_ovl_pkg::*;
#(
  parameter int COORD_W = 16,
  parameter int COLOR_W = 24
) (
  input  logic               clk,
  input  logic               rstN,
  input  cursStrobe_t        strobe,
  output logic [DATA_W-1:0]  regRdData,
  input  logic [COORD_W-1:0] scanX,
  input  logic [COORD_W-1:0] scanY,
  input  logic [COORD_W-1:0] activeWidth,
  input  logic [COLOR_W-1:0] pixIn,
  input  logic [COLOR_W-1:0] ovlSetColor,
  input  logic [COLOR_W-1:0] ovlClrColor,
  output logic [COLOR_W-1:0] pixOut
);
  localparam int ROWS = DATA_W;
  localparam logic [COORD_W-1:0] RST_POS = COORD_W'(RESET_COORD);
  localparam logic [COORD_W:0]   SPAN    = (COORD_W+1)'(DATA_W);
  localparam int HALF = DATA_W / 2;

  // pending (bus side) and active (display side) copies
  logic [COORD_W-1:0] pendX, pendY, actX, actY;
  logic [DATA_W-1:0]  pendMask [ROWS];
  logic [DATA_W-1:0]  pendImg  [ROWS];
  logic [DATA_W-1:0]  actMask  [ROWS];
  logic [DATA_W-1:0]  actImg   [ROWS];
  logic [DATA_W-1:0]  miscWord;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendX <= RST_POS;
      pendY <= RST_POS;
      actX  <= RST_POS;
      actY  <= RST_POS;
      miscWord <= '0;
    end else begin
      if (strobe.wrPos) begin
        pendX <= COORD_W'(strobe.data[DATA_W-1:HALF]);
        pendY <= COORD_W'(strobe.data[HALF-1:0]);
      end
      if (strobe.wrMisc) miscWord <= strobe.data;
      if (strobe.load) begin
        actX <= pendX;
        actY <= pendY;
      end
    end
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    always_ff @(posedge clk) begin
      if (!rstN) begin
        pendMask[r] <= '0;
        pendImg[r]  <= '0;
        actMask[r]  <= '0;
        actImg[r]   <= '0;
      end else begin
        if (strobe.wrMask && strobe.row == ROW_W'(r)) pendMask[r] <= strobe.data;
        if (strobe.wrImg  && strobe.row == ROW_W'(r)) pendImg[r]  <= strobe.data;
        if (strobe.load) begin
          actMask[r] <= pendMask[r];
          actImg[r]  <= pendImg[r];
        end
      end
    end
  end

  // register readback
  always_ff @(posedge clk) begin
    if (!rstN) regRdData <= '0;
    else if (strobe.rdMisc) regRdData <= miscWord | (DATA_W'(1) << MISC_FORCE_BIT);
    else regRdData <= '0;
  end

  // overlay decision
  logic               rowHit, colHit, inLine, onScreen;
  logic [COORD_W-1:0] dy, dx;
  logic [ROW_W-1:0]   rowSel, bitSel;
  logic               maskBit, imgBit;
  logic [COLOR_W-1:0] mixed;

  always_comb begin
    dy       = scanY - actY;
    dx       = scanX - actX;
    rowHit   = (scanY >= actY) && ({1'b0, scanY} < ({1'b0, actY} + SPAN));
    colHit   = (scanX >= actX) && ({1'b0, scanX} < ({1'b0, actX} + SPAN));
    inLine   = (scanX < activeWidth);
    onScreen = (actX < activeWidth);
    rowSel   = dy[ROW_W-1:0];
    bitSel   = ~dx[ROW_W-1:0];           // leftmost pixel is the top bit
    maskBit  = actMask[rowSel][bitSel];
    imgBit   = actImg[rowSel][bitSel];
    mixed    = pixIn;
    if (rowHit && colHit && inLine && onScreen && maskBit)
      mixed = imgBit ? ovlSetColor : ovlClrColor;
  end

  always_ff @(posedge clk) begin
    if (!rstN) pixOut <= '0;
    else pixOut <= mixed;
  end

  // R6: columns past the line end always pass through
  a_r6_clip_line_end: assert property (@(posedge clk) disable iff (!rstN)
    (scanX >= activeWidth) |=> (pixOut == $past(pixIn)));
  // R4: lines outside the active window pass through
  a_r4_rows_outside: assert property (@(posedge clk) disable iff (!rstN)
    (!rowHit) |=> (pixOut == $past(pixIn)));
  // R9: active position holds between frame-start pulses
  a_r9_hold_pos: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.load) |=> ($stable(actX) && $stable(actY)));
  // R7: misc reads always show the forced bit
  a_r7_misc_bit: assert property (@(posedge clk) disable iff (!rstN)
    strobe.rdMisc |=> regRdData[MISC_FORCE_BIT]);
  // R8: other reads give zero
  a_r8_other_zero: assert property (@(posedge clk) disable iff (!rstN)
    strobe.rdOther |=> (regRdData == '0));
  // R5: output is one of the three legal sources
  a_r5_legal_src: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (pixOut == $past(pixIn) || pixOut == $past(ovlSetColor)
              || pixOut == $past(ovlClrColor)));
endmodule

// File: rtl/cursor_ovl_top.sv
module cursor_ovl_top
  import cursor_ovl_pkg::*;
#(
  parameter int COORD_W = 16,
  parameter int COLOR_W = 24
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic               regRdEn,
  input  logic [11:0]        regAddr,
  input  logic [31:0]        regWrData,
  output logic [31:0]        regRdData,
  input  logic               frameStart,
  input  logic [COORD_W-1:0] scanX,
  input  logic [COORD_W-1:0] scanY,
  input  logic [COORD_W-1:0] activeWidth,
  input  logic [COLOR_W-1:0] pixIn,
  input  logic [COLOR_W-1:0] ovlSetColor,
  input  logic [COLOR_W-1:0] ovlClrColor,
  output logic [COLOR_W-1:0] pixOut
);
  cursStrobe_t strobe;

  cursor_ovl_ctl u_ctl (
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr),
    .regWrData(regWrData), .frameStart(frameStart), .strobe(strobe)
  );

  cursor_ovl_dp #(.COORD_W(COORD_W), .COLOR_W(COLOR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .regRdData(regRdData),
    .scanX(scanX), .scanY(scanY), .activeWidth(activeWidth), .pixIn(pixIn),
    .ovlSetColor(ovlSetColor), .ovlClrColor(ovlClrColor), .pixOut(pixOut)
  );
endmodule

// File: tb/cursor_ovl_top_test.sv
module cursor_ovl_top_test;
  logic        clk = 0, rstN = 0;
  logic        regWrEn = 0, regRdEn = 0, frameStart = 0;
  logic [11:0] regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [15:0] scanX = '0, scanY = '0, activeWidth = 16'd48;
  logic [23:0] pixIn = '0;
  logic [23:0] ovlSetColor = 24'h5A5A5A, ovlClrColor = 24'hA5A5A5;
  logic [23:0] pixOut;
  int nChecks = 0, nFails = 0;
  bit done = 0;

  // bench model: pending and active cursor state
  logic [31:0] pMask [32], pImg [32], aMask [32], aImg [32];
  int pcx = 'hF000, pcy = 'hF000, acx = 'hF000, acy = 'hF000;

  cursor_ovl_top uut (.*);

  always #5 clk = ~clk;

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: run did not finish (actual hung, expected done)");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  function automatic logic [23:0] pixFor(int x, int y);
    return {8'h11, 8'(y), 8'(x)};
  endfunction

  function automatic logic [23:0] expPix(int x, int y, int w);
    int b, r;
    if (y >= acy && y < acy + 32 && x >= acx && x < acx + 32 && x < w && acx < w) begin
      b = 31 - (x - acx);
      r = y - acy;
      if (aMask[r][b]) return aImg[r][b] ? ovlSetColor : ovlClrColor;
    end
    return pixFor(x, y);
  endfunction

  task automatic wrReg(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1; regAddr = a; regWrData = d;
    @(posedge clk); #1;
    regWrEn = 0;
    if (a == 12'h8FC) begin pcx = int'(d[31:16]); pcy = int'(d[15:0]); end
    if (a >= 12'h900 && a < 12'h980) pMask[(a - 12'h900) >> 2] = d;
    if (a >= 12'h980 && a < 12'hA00) pImg[(a - 12'h980) >> 2] = d;
  endtask

  task automatic frame();
    @(negedge clk);
    frameStart = 1;
    @(posedge clk); #1;
    frameStart = 0;
    acx = pcx; acy = pcy;
    for (int i = 0; i < 32; i++) begin aMask[i] = pMask[i]; aImg[i] = pImg[i]; end
  endtask

  task automatic rdReg(input logic [11:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    regRdEn = 1; regAddr = a;
    @(posedge clk); #1;
    regRdEn = 0;
    nChecks++;
    if (regRdData !== exp) begin
      nFails++;
      $display("FAIL %s: read 0x%03h actual %08h expected %08h", tag, a, regRdData, exp);
    end
  endtask

  // R10: each vector is sampled just after the next rising edge
  task automatic sweep(int x0, int x1, int y0, int y1, int w, string tag);
    logic [23:0] e;
    for (int y = y0; y <= y1; y++) begin
      for (int x = x0; x <= x1; x++) begin
        @(negedge clk);
        scanX = 16'(x); scanY = 16'(y); activeWidth = 16'(w); pixIn = pixFor(x, y);
        e = expPix(x, y, w);
        @(posedge clk); #1;
        nChecks++;
        if (pixOut !== e) begin
          nFails++;
          $display("FAIL %s: (%0d,%0d) actual %06h expected %06h", tag, x, y, pixOut, e);
        end
      end
    end
  endtask

  initial begin
    for (int i = 0; i < 32; i++) begin
      pMask[i] = '0; pImg[i] = '0; aMask[i] = '0; aImg[i] = '0;
    end
    repeat (3) @(posedge clk);
    #1 rstN = 1;

    // R1: reset state
    sweep(0, 39, 0, 3, 48, "R1");
    sweep('hEFFE, 'hF003, 'hEFFF, 'hF001, 'hFFFF, "R1");
    rdReg(12'h818, 32'h0200_0000, "R1");

    // R2 R3: load shape and position, not yet committed
    for (int r = 0; r < 32; r++) begin
      wrReg(12'h900 + 12'(4*r), 32'h9E37_79B9 * (r + 1));
      wrReg(12'h980 + 12'(4*r), 32'h7F4A_7C15 * (r + 3));
    end
    wrReg(12'h8FC, {16'd5, 16'd3});
    sweep(0, 47, 0, 37, 48, "R9");          // R9: nothing visible yet
    frame();
    sweep(0, 47, 0, 37, 48, "R4_R5_R2");    // R4 R5 R2 R10

    // R6: partly clipped at the line end
    wrReg(12'h8FC, {16'd30, 16'd0});
    frame();
    sweep(25, 63, 0, 33, 48, "R6");
    // R6: cursor starting exactly at the line end
    wrReg(12'h8FC, {16'd48, 16'd2});
    frame();
    sweep(44, 63, 0, 35, 48, "R6");
    sweep(44, 63, 0, 35, 64, "R6");

    // R3: first and last rows by their offsets
    wrReg(12'h97C, 32'hFFFF_FFFF);
    wrReg(12'h9FC, 32'h0000_FFFF);
    wrReg(12'h900, 32'hF0F0_0001);
    wrReg(12'h980, 32'h8000_0001);
    wrReg(12'h8FC, {16'd0, 16'd0});
    frame();
    sweep(0, 35, 0, 0, 48, "R3");
    sweep(0, 35, 31, 32, 48, "R3");

    // R7 R8: readback
    wrReg(12'h818, 32'h0000_00A5);
    rdReg(12'h818, 32'h0200_00A5, "R7");
    wrReg(12'h818, 32'hFFFF_FFFF);
    rdReg(12'h818, 32'hFFFF_FFFF, "R7");
    rdReg(12'h8FC, 32'h0, "R8");
    rdReg(12'h900, 32'h0, "R8");
    rdReg(12'h9FC, 32'h0, "R8");
    rdReg(12'h81C, 32'h0, "R8");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule